// File: doc/BRIEF.md
# Paged monochrome LCD frame buffer controller

This block holds the picture for a 128 by 64 one-bit display and is written through a 32-bit register bus. The frame store is split into pages. Each page is eight pixel rows tall and 128 columns wide. Each byte covers one column of one page, and its bit k is the pixel in row k of that page.

A mode state machine decides what a write to the data register does. It has three states: `MODE_OFF`, `MODE_CMD` and `MODE_PIX`. Writing the command key to the mode register moves any state to `MODE_CMD`. Writing the pixel key moves any state to `MODE_PIX`. Writing any other value moves any state to `MODE_OFF`. There are no other transitions.

A page-select command sets the write page and clears the column offset. Each pixel byte is stored at the current page and column, and the column then steps forward, wrapping within the page. A pixel query port returns, one cycle after a request, whether a pixel is lit, together with its colour. The colour of a lit pixel is the base colour E0E0FF scaled by a 3-bit brightness level. An unlit pixel is black.

Top module: `lcd_fb_ctrl`

## Requirements
- R1: After reset the mode state is `MODE_OFF` (the mode register reads 0), the write page and column are 0, the brightness reads 7, both interrupt registers read 0 and `px_valid` is low.
- R2: A write to the mode register (offset 0x1AC) enters `MODE_CMD` for value 0x00104011 and `MODE_PIX` for 0x00100011. Any other value enters `MODE_OFF`. The mode register reads back 0x00104011, 0x00100011 or 0, according to the state.
- R3: In any mode, writing a value from 0xB0 to 0xB7 to the instruction register (offset 0x1BC) selects page value−0xB0 and clears the column to 0. Any other value written there has no effect.
- R4: In `MODE_CMD`, a data-register (offset 0x1C0) write of 0xB0 to 0xB7 selects a page in the same way as R3. Any other value written in this mode is neither stored nor changes the page or column.
- R5: In `MODE_PIX`, a data-register write stores bits 7:0 at byte page*128 + column, then the column steps by one modulo 128. The page is left unchanged.
- R6: In `MODE_OFF`, data-register writes store nothing and leave the page and column unchanged.
- R7: A query with `px_req` high for (x, y) makes `px_valid` go high on the next cycle. At that point `px_on` equals bit (y mod 8) of byte x + (y div 8)*128. With no request, `px_valid` is low on the next cycle.
- R8: The brightness register (offset 0x1D0, bits 2:0) sets level L. For a lit pixel, `px_rgb` is {floor(0xE0*L/7), floor(0xE0*L/7), floor(0xFF*L/7)} with red in bits 23:16 and blue in bits 7:0. For an unlit pixel it is 0.
- R9: The interrupt control (0x180) and interrupt status (0x184) registers read back the last 32-bit value written. A read returns data with `bus_rvalid` high on the cycle after `bus_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| px_req | input | 1 | Pixel query request |
| px_x | input | 7 | Query column |
| px_y | input | 6 | Query row |
| px_valid | output | 1 | Query result valid |
| px_on | output | 1 | Queried pixel is lit |
| px_rgb | output | 24 | Scaled colour of the queried pixel |

## Verification
Pixel bytes with uneven bit patterns (A5, 3C, 81, 0F, F0, 55) are read back over all eight rows of a page. Any swap of bit order, or any mix-up of page and column, therefore shows up as a wrong row.

Data writes are interleaved with switches into `MODE_OFF` and `MODE_CMD`. Stray bytes written in those modes must leave both the stored bytes and the column offset untouched, and an ignored instruction value (0xB8) must leave the page in place.

A full page of 128 bytes followed by one extra write separates a correct wrap within the page from a spill into the next page. Sweeping all eight brightness levels over one lit pixel and one unlit pixel checks the rounding of each colour channel.

// File: rtl/lcd_fb_pkg.sv
package lcd_fb_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_CMD = 2'd1,
        MODE_PIX = 2'd2
    } lcd_mode_e;

    localparam logic [11:0] REG_IRQ_CTL = 12'h180;
    localparam logic [11:0] REG_IRQ_STS = 12'h184;
    localparam logic [11:0] REG_MODE    = 12'h1AC;
    localparam logic [11:0] REG_INSTR   = 12'h1BC;
    localparam logic [11:0] REG_DATA    = 12'h1C0;
    localparam logic [11:0] REG_BRIGHT  = 12'h1D0;

    localparam logic [31:0] KEY_PIX = 32'h0010_0011;
    localparam logic [31:0] KEY_CMD = 32'h0010_4011;

    localparam logic [7:0]  PAGE_CMD_BASE = 8'hB0;
    localparam logic [23:0] LIT_RGB       = 24'hE0E0FF;

    function automatic logic page_cmd_hit(input logic [31:0] v, input int unsigned pages);
        return (v >= 32'(PAGE_CMD_BASE)) && (v < 32'(PAGE_CMD_BASE) + 32'(pages));
    endfunction

endpackage

// File: rtl/lcd_fb_mode_fsm.sv
module lcd_fb_mode_fsm
    import lcd_fb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [31:0] mode_val,
    output lcd_mode_e   mode_q,
    output logic [31:0] mode_word
);

    lcd_mode_e state_d;

    // Next-state selection: every mode write picks a state, an unknown key means off.
    always_comb begin
        state_d = mode_q;
        if (mode_wr) begin
            if (mode_val == KEY_CMD) begin
                state_d = MODE_CMD;
            end else if (mode_val == KEY_PIX) begin
                state_d = MODE_PIX;
            end else begin
                state_d = MODE_OFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= state_d;
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_OFF: mode_word = 32'd0;
            MODE_CMD: mode_word = KEY_CMD;
            MODE_PIX: mode_word = KEY_PIX;
            default:  mode_word = 32'd0;
        endcase
    end

endmodule

// File: rtl/lcd_fb_cursor.sv
module lcd_fb_cursor #(
    parameter int PAGE_W = 3,
    parameter int COL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic [PAGE_W-1:0] sel_page,
    input  logic              adv,
    output logic [PAGE_W-1:0] page_q,
    output logic [COL_W-1:0]  col_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (sel_en) begin
            page_q <= sel_page;
            col_q  <= '0;
        end else if (adv) begin
            col_q  <= col_q + 1'b1;   // wraps inside the page
        end
    end

endmodule

// File: rtl/lcd_fb_mem.sv
module lcd_fb_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wbyte,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rbyte
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wbyte;
        end
        if (re) begin
            rbyte <= store[raddr];
        end
    end

endmodule

// File: rtl/lcd_fb_scale.sv
module lcd_fb_scale #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] level,
    input  logic [7:0]       comp,
    output logic [7:0]       scaled
);

    localparam int MAXL = (1 << LVL_W) - 1;
    localparam int PW   = 8 + LVL_W;

    logic [PW-1:0] prod;

    assign prod   = PW'(comp) * PW'(level);
    assign scaled = 8'(prod / PW'(MAXL));

endmodule

// File: rtl/lcd_fb_ctrl.sv
module lcd_fb_ctrl
    import lcd_fb_pkg::*;
#(
    parameter int COLS   = 128,
    parameter int PAGES  = 8,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic                        px_req,
    input  logic [$clog2(COLS)-1:0]     px_x,
    input  logic [$clog2(PAGES)+2:0]    px_y,
    output logic                        px_valid,
    output logic                        px_on,
    output logic [23:0]                 px_rgb
);

    localparam int COL_W  = $clog2(COLS);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int ROW_W  = PAGE_W + 3;
    localparam int FB_AW  = PAGE_W + COL_W;
    localparam int DEPTH  = COLS * PAGES;
    localparam int CHANS  = 3;

    // Register decode
    logic       hit_mode, hit_instr, hit_data, hit_bright, hit_ictl, hit_ists;
    logic       page_val;
    lcd_mode_e  mode_q;
    logic [31:0] mode_word;

    assign hit_mode   = bus_wr && (bus_addr == ADDR_W'(REG_MODE));
    assign hit_instr  = bus_wr && (bus_addr == ADDR_W'(REG_INSTR));
    assign hit_data   = bus_wr && (bus_addr == ADDR_W'(REG_DATA));
    assign hit_bright = bus_wr && (bus_addr == ADDR_W'(REG_BRIGHT));
    assign hit_ictl   = bus_wr && (bus_addr == ADDR_W'(REG_IRQ_CTL));
    assign hit_ists   = bus_wr && (bus_addr == ADDR_W'(REG_IRQ_STS));
    assign page_val   = page_cmd_hit(32'(bus_wdata), PAGES);

    lcd_fb_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (hit_mode),
        .mode_val  (32'(bus_wdata)),
        .mode_q    (mode_q),
        .mode_word (mode_word)
    );

    // Write pointer
    logic              sel_en, pix_wr;
    logic [PAGE_W-1:0] sel_page, page_q;
    logic [COL_W-1:0]  col_q;

    assign sel_en   = (hit_instr && page_val) ||
                      (hit_data && (mode_q == MODE_CMD) && page_val);
    assign sel_page = PAGE_W'(bus_wdata - DATA_W'(PAGE_CMD_BASE));
    assign pix_wr   = hit_data && (mode_q == MODE_PIX);

    lcd_fb_cursor #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_en   (sel_en),
        .sel_page (sel_page),
        .adv      (pix_wr),
        .page_q   (page_q),
        .col_q    (col_q)
    );

    // Frame store
    logic [7:0] rbyte;

    lcd_fb_mem #(.DEPTH(DEPTH), .AW(FB_AW)) u_mem (
        .clk   (clk),
        .we    (pix_wr),
        .waddr ({page_q, col_q}),
        .wbyte (bus_wdata[7:0]),
        .re    (px_req),
        .raddr ({px_y[ROW_W-1:3], px_x}),
        .rbyte (rbyte)
    );

    // Plain registers
    logic [DATA_W-1:0] ictl_q, ists_q;
    logic [LVL_W-1:0]  bright_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ictl_q   <= '0;
            ists_q   <= '0;
            bright_q <= '1;
        end else begin
            if (hit_ictl)   ictl_q   <= bus_wdata;
            if (hit_ists)   ists_q   <= bus_wdata;
            if (hit_bright) bright_q <= bus_wdata[LVL_W-1:0];
        end
    end

    // Register read path, one cycle of latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                if (bus_addr == ADDR_W'(REG_IRQ_CTL)) begin
                    bus_rdata <= ictl_q;
                end else if (bus_addr == ADDR_W'(REG_IRQ_STS)) begin
                    bus_rdata <= ists_q;
                end else if (bus_addr == ADDR_W'(REG_MODE)) begin
                    bus_rdata <= DATA_W'(mode_word);
                end else if (bus_addr == ADDR_W'(REG_BRIGHT)) begin
                    bus_rdata <= DATA_W'(bright_q);
                end else begin
                    bus_rdata <= '0;
                end
            end
        end
    end

    // Pixel query result
    logic [2:0] bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_valid <= 1'b0;
            bit_q    <= '0;
        end else begin
            px_valid <= px_req;
            if (px_req) bit_q <= px_y[2:0];
        end
    end

    logic [23:0] scaled_rgb;

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        lcd_fb_scale #(.LVL_W(LVL_W)) u_scale (
            .level  (bright_q),
            .comp   (LIT_RGB[c*8 +: 8]),
            .scaled (scaled_rgb[c*8 +: 8])
        );
    end

    assign px_on  = px_valid && rbyte[bit_q];
    assign px_rgb = px_on ? scaled_rgb : 24'd0;

endmodule

// File: rtl/lcd_fb_chk.sv
module lcd_fb_chk
    import lcd_fb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int COL_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic              px_req,
    input logic              px_valid,
    input logic              px_on,
    input logic [23:0]       px_rgb,
    input logic [1:0]        mode_q,
    input logic [COL_W-1:0]  col_q
);

    assert_bad_key_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_MODE) &&
         bus_wdata != DATA_W'(KEY_CMD) && bus_wdata != DATA_W'(KEY_PIX))
        |=> (mode_q == 2'(MODE_OFF)));

    assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_DATA) && mode_q == 2'(MODE_PIX))
        |=> (col_q == COL_W'($past(col_q) + 1'b1)));

    assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_DATA) && mode_q == 2'(MODE_OFF))
        |=> $stable(col_q));

    assert_query_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        px_req |=> px_valid);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !px_req |=> !px_valid);

    assert_dark_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_on) |-> (px_rgb == 24'd0));

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

endmodule

bind lcd_fb_ctrl lcd_fb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .px_req     (px_req),
    .px_valid   (px_valid),
    .px_on      (px_on),
    .px_rgb     (px_rgb),
    .mode_q     (mode_q),
    .col_q      (col_q)
);

// File: tb/lcd_fb_ctrl_tb.sv
module lcd_fb_ctrl_tb;
    import lcd_fb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        px_req = 1'b0;
    logic [6:0]  px_x = '0;
    logic [5:0]  px_y = '0;
    logic        px_valid, px_on;
    logic [23:0] px_rgb;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_fb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .px_req(px_req), .px_x(px_x), .px_y(px_y),
        .px_valid(px_valid), .px_on(px_on), .px_rgb(px_rgb)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state, built from the requirements
    logic [7:0]  fb_m [1024];
    int          m_mode = 0, m_page = 0, m_col = 0, m_bright = 7;

    logic [31:0] reg_q [$];
    string       reg_tag [$];
    logic [24:0] pix_q [$];
    string       pix_tag [$];

    function automatic logic [7:0] scl(input logic [7:0] c, input int l);
        return 8'((int'(c) * l) / 7);
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == REG_MODE) begin
            m_mode = (d == KEY_CMD) ? 1 : (d == KEY_PIX) ? 2 : 0;
        end else if (a == REG_INSTR) begin
            if (d >= 32'hB0 && d <= 32'hB7) begin m_page = int'(d - 32'hB0); m_col = 0; end
        end else if (a == REG_DATA) begin
            if (m_mode == 1 && d >= 32'hB0 && d <= 32'hB7) begin
                m_page = int'(d - 32'hB0); m_col = 0;
            end else if (m_mode == 2) begin
                fb_m[m_page*128 + m_col] = d[7:0];
                m_col = (m_col + 1) % 128;
            end
        end else if (a == REG_BRIGHT) begin
            m_bright = int'(d[2:0]);
        end
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_q.push_back(exp);
        reg_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic px_query(input int x, input int y, input string tag);
        logic on;
        on = fb_m[x + (y/8)*128][y%8];
        pix_q.push_back({on, on ? {scl(8'hE0, m_bright), scl(8'hE0, m_bright), scl(8'hFF, m_bright)} : 24'd0});
        pix_tag.push_back(tag);
        @(negedge clk);
        px_req = 1'b1; px_x = 7'(x); px_y = 6'(y);
        @(negedge clk);
        px_req = 1'b0;
    endtask

    // Monitor: pops expected items as the design produces results
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rvalid) begin
                n_cmp++;
                if (reg_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R9 unexpected read data actual=%h expected=none", bus_rdata);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = reg_q.pop_front();
                    t = reg_tag.pop_front();
                    if (bus_rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                    end
                end
            end
            if (px_valid) begin
                n_cmp++;
                if (pix_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected pixel result actual=%b expected=none", px_on);
                end else begin
                    logic [24:0] e;
                    string t;
                    e = pix_q.pop_front();
                    t = pix_tag.pop_front();
                    if ({px_on, px_rgb} !== e) begin
                        n_bad++;
                        $display("FAIL %s pixel actual=%h expected=%h", t, {px_on, px_rgb}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) fb_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        n_cmp++;
        if (px_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 px_valid after reset actual=%b expected=0", px_valid);
        end
        bus_read(REG_MODE,    32'd0, "R1");
        bus_read(REG_BRIGHT,  32'd7, "R1");
        bus_read(REG_IRQ_CTL, 32'd0, "R1");
        bus_read(REG_IRQ_STS, 32'd0, "R1");

        // R9: readback registers and unmapped offset
        bus_write(REG_IRQ_CTL, 32'hDEAD_BEEF);
        bus_write(REG_IRQ_STS, 32'h1234_5678);
        bus_read(REG_IRQ_CTL, 32'hDEAD_BEEF, "R9");
        bus_read(REG_IRQ_STS, 32'h1234_5678, "R9");
        bus_read(12'h000,     32'd0,         "R9");

        // R2: mode keys
        bus_write(REG_MODE, 32'h0000_1234);
        bus_read(REG_MODE, 32'd0, "R2");
        bus_write(REG_MODE, KEY_CMD);
        bus_read(REG_MODE, KEY_CMD, "R2");
        bus_write(REG_MODE, KEY_PIX);
        bus_read(REG_MODE, KEY_PIX, "R2");
        bus_write(REG_MODE, KEY_PIX ^ 32'h1);
        bus_read(REG_MODE, 32'd0, "R2");

        // R5/R6: store, then stray writes in off mode
        bus_write(REG_MODE, KEY_PIX);
        bus_write(REG_INSTR, 32'hB0);
        bus_write(REG_DATA, 32'hA5);
        bus_write(REG_DATA, 32'h3C);
        bus_write(REG_MODE, 32'h0);
        bus_write(REG_DATA, 32'hFF);
        bus_write(REG_DATA, 32'hFF);
        bus_write(REG_MODE, KEY_PIX);
        bus_write(REG_DATA, 32'h81);
        for (int y = 0; y < 8; y++) px_query(0, y, "R7");
        for (int y = 0; y < 8; y++) px_query(1, y, "R6");
        for (int y = 0; y < 8; y++) px_query(2, y, "R6");

        // R3: instruction page select, ignored out-of-range value
        bus_write(REG_INSTR, 32'hB3);
        bus_write(REG_DATA, 32'h0F);
        bus_write(REG_INSTR, 32'hB8);
        bus_write(REG_DATA, 32'hF0);
        for (int y = 24; y < 32; y++) px_query(0, y, "R3");
        for (int y = 24; y < 32; y++) px_query(1, y, "R3");

        // R4: page select via data register in command mode
        bus_write(REG_MODE, KEY_CMD);
        bus_write(REG_DATA, 32'hB5);
        bus_write(REG_DATA, 32'h42);
        bus_write(REG_MODE, KEY_PIX);
        bus_write(REG_DATA, 32'h55);
        bus_write(REG_DATA, 32'h66);
        for (int y = 40; y < 48; y++) px_query(0, y, "R4");
        for (int y = 40; y < 48; y++) px_query(1, y, "R4");

        // R5: full page plus one wraps to column 0 of the same page
        bus_write(REG_INSTR, 32'hB7);
        for (int i = 0; i < 128; i++) bus_write(REG_DATA, 32'(i));
        bus_write(REG_DATA, 32'hEE);
        for (int y = 56; y < 64; y++) px_query(0, y, "R5");
        for (int y = 56; y < 64; y++) px_query(127, y, "R5");
        for (int y = 0; y < 8; y++) px_query(0, y, "R5");

        // R8: brightness sweep on a lit and an unlit pixel
        for (int l = 0; l < 8; l++) begin
            bus_write(REG_BRIGHT, 32'(l));
            bus_read(REG_BRIGHT, 32'(l), "R8");
            px_query(0, 57, "R8");
            px_query(0, 56, "R8");
        end

        repeat (4) @(negedge clk);
        n_cmp++;
        if (reg_q.size() != 0 || pix_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 pending results actual=%0d expected=0", reg_q.size() + pix_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule